// File: doc/BRIEF.md
# Dual-Clock Low-Power Compare Timer

This block is an up-counting timer that can wake the system. Software programs it through a small register interface clocked by a fast bus clock. The count itself advances in a slow, independent engine clock domain. A prescaler divides the engine clock. The counter runs freely in continuous mode. When the count reaches the programmed compare value, an interrupt flag and a wakeup flag are set together. Each flag drives an output when its enable bit is set.

Control and compare writes land in bus-side holding registers and read back at once. They are carried into the engine domain by a toggle handshake, so they take effect a few engine clocks later. The running count returns to the bus through a Gray-coded synchroniser. A read of the count therefore never mixes bits from two different values. An active bit in the control word tells software when a start or stop has actually reached the counter.

Top module: `lp_cmp_timer`

## Requirements
- R1: After reset, all four registers read zero, the count is zero, and `irq_o` and `wake_o` are low.
- R2: A compare value below 2 (including 0 and 1) behaves as 2. The flags set when the count reaches the effective compare value.
- R3: With prescale value p (control bits [8+:7], 0 to 127), the count advances once every p+1 engine clocks while running.
- R4: Writing a new compare value while the counter runs neither resets nor disturbs the count, and the new value is used for the next match.
- R5: A start issued while stopped restarts the count from zero. While stopped, the count holds its value.
- R6: Address 0 is control: bit0 run, bit1 interrupt enable, bit2 wakeup enable, bits [8+:7] prescale, bit31 active (read-only). Address 1 is compare, address 2 is status, address 3 is the count (read-only). Control and compare read back the written value on the very next bus cycle, before the value has effect in the engine domain.
- R7: Status bit0 is the interrupt flag and bit1 is the wakeup flag. A match sets both in the same cycle. Writing 1 to a bit clears that flag, and one write may clear either flag or both.
- R8: The count wraps from its maximum (2^CNT_W-1) to 0 and keeps running. A compare value equal to the maximum matches.
- R9: The active bit reads 1 only after a start has reached the engine domain and counting has begun. It reads 0 again once a stop has taken effect.
- R10: `irq_o` is the interrupt flag ANDed with the interrupt enable, and `wake_o` is the wakeup flag ANDed with the wakeup enable. Both are registered in the bus clock.
- R11: Count reads taken while running are coherent: consecutive reads never step backwards or jump by more than one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain reset, active low |
| eclk | input | 1 | Engine (counting) clock |
| erst_n | input | 1 | Engine-domain reset, active low |
| bwe | input | 1 | Register write strobe |
| baddr | input | 2 | Register address |
| bwdata | input | 32 | Write data |
| brdata | output | 32 | Read data for `baddr`, combinational |
| irq_o | output | 1 | Interrupt output |
| wake_o | output | 1 | Wakeup output |

## Verification
The assertions assume the following about the inputs:
- Successive control or compare writes are spaced further apart than the toggle handshake latency, so the holding registers are stable whenever the engine captures them.
- The engine clock is slower than the bus clock, so each match toggle is seen by the bus.
- A stop is allowed to settle before the next start. This keeps the Gray-code single-step check valid while the active bit is high.

The stimulus meets these conditions:
- The engine clock is a quarter of the bus clock rate, with a phase offset.
- Every stop waits until the active bit has fallen.
- Register writes are separated by register reads or by explicit waits.

// File: rtl/lp_cmp_timer.sv
module lp_cmp_timer #(
  parameter int CNT_W   = 24,
  parameter int PSC_W   = 7,
  parameter int CMP_MIN = 2
) (
  input  logic        bclk,
  input  logic        brst_n,
  input  logic        eclk,
  input  logic        erst_n,
  input  logic        bwe,
  input  logic [1:0]  baddr,
  input  logic [31:0] bwdata,
  output logic [31:0] brdata,
  output logic        irq_o,
  output logic        wake_o
);

  localparam int PSC_LSB = 8;
  localparam logic [CNT_W-1:0] CMP_FLOOR = CNT_W'(CMP_MIN);

  function automatic logic [CNT_W-1:0] g2b(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // bus-domain state
  logic             run_b, ien_b, wen_b, cfg_t;
  logic [PSC_W-1:0] psc_b;
  logic [CNT_W-1:0] cmp_b;
  logic             irq_f, wake_f;
  logic [2:0]       hit_s;
  logic [1:0]       act_s;
  logic [CNT_W-1:0] g_s1, g_s2;

  // engine-domain state
  logic [2:0]       cfg_s;
  logic             run_e, act_e, mt_e, hit_e;
  logic [PSC_W-1:0] psc_e, pcnt, pcnt_d;
  logic [CNT_W-1:0] cmp_e, cnt, cnt_d, gray_e;

  wire act_b  = act_s[1];
  wire hit_b  = hit_s[2] ^ hit_s[1];
  wire clr_wr = bwe && baddr == 2'd2;
  wire unused_wdata = ^bwdata;

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      run_b <= 1'b0; ien_b <= 1'b0; wen_b <= 1'b0; cfg_t <= 1'b0;
      psc_b <= '0; cmp_b <= '0;
      irq_f <= 1'b0; wake_f <= 1'b0;
      hit_s <= '0; act_s <= '0; g_s1 <= '0; g_s2 <= '0;
      irq_o <= 1'b0; wake_o <= 1'b0;
    end else begin
      if (bwe && baddr == 2'd0) begin
        run_b <= bwdata[0];
        ien_b <= bwdata[1];
        wen_b <= bwdata[2];
        psc_b <= bwdata[PSC_LSB +: PSC_W];
        cfg_t <= ~cfg_t;
      end
      if (bwe && baddr == 2'd1) begin
        cmp_b <= bwdata[CNT_W-1:0];
        cfg_t <= ~cfg_t;
      end
      hit_s  <= {hit_s[1:0], mt_e};
      act_s  <= {act_s[0], act_e};
      g_s1   <= gray_e;
      g_s2   <= g_s1;
      irq_f  <= hit_b | (irq_f  & ~(clr_wr & bwdata[0]));
      wake_f <= hit_b | (wake_f & ~(clr_wr & bwdata[1]));
      irq_o  <= irq_f & ien_b;
      wake_o <= wake_f & wen_b;
    end
  end

  always_comb begin
    brdata = '0;
    case (baddr)
      2'd0: begin
        brdata[0] = run_b;
        brdata[1] = ien_b;
        brdata[2] = wen_b;
        brdata[PSC_LSB +: PSC_W] = psc_b;
        brdata[31] = act_b;
      end
      2'd1:    brdata[CNT_W-1:0] = cmp_b;
      2'd2:    brdata[1:0] = {wake_f, irq_f};
      default: brdata[CNT_W-1:0] = g2b(g_s2);
    endcase
  end

  // engine domain
  wire             cfg_ld  = cfg_s[2] ^ cfg_s[1];
  wire             start_e = cfg_ld & run_b & ~run_e;
  wire             tick_e  = run_e & (pcnt >= psc_e);
  wire [CNT_W-1:0] cmp_eff = (cmp_e < CMP_FLOOR) ? CMP_FLOOR : cmp_e;

  always_comb begin
    cnt_d  = cnt;
    pcnt_d = pcnt;
    hit_e  = 1'b0;
    if (start_e) begin
      cnt_d  = '0;
      pcnt_d = '0;
    end else if (tick_e) begin
      cnt_d  = cnt + 1'b1;
      pcnt_d = '0;
      hit_e  = (cnt_d == cmp_eff);
    end else if (run_e) begin
      pcnt_d = pcnt + 1'b1;
    end
  end

  always_ff @(posedge eclk or negedge erst_n) begin
    if (!erst_n) begin
      cfg_s <= '0; run_e <= 1'b0; psc_e <= '0; cmp_e <= '0;
      cnt <= '0; pcnt <= '0; gray_e <= '0; act_e <= 1'b0; mt_e <= 1'b0;
    end else begin
      cfg_s <= {cfg_s[1:0], cfg_t};
      if (cfg_ld) begin
        run_e <= run_b;
        psc_e <= psc_b;
        cmp_e <= cmp_b;
      end
      cnt    <= cnt_d;
      pcnt   <= pcnt_d;
      gray_e <= cnt_d ^ (cnt_d >> 1);
      act_e  <= run_e;
      mt_e   <= mt_e ^ hit_e;
    end
  end

  assert_step_wrap_R8: assert property (@(posedge eclk) disable iff (!erst_n)
    ($past(run_e) && run_e) |-> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_prescale_R3: assert property (@(posedge eclk) disable iff (!erst_n)
    ($past(run_e) && cnt != $past(cnt)) |-> ($past(pcnt) >= $past(psc_e)));

  assert_restart_zero_R5: assert property (@(posedge eclk) disable iff (!erst_n)
    (!$past(run_e) && run_e) |-> (cnt == '0));

  assert_hold_stopped_R5: assert property (@(posedge eclk) disable iff (!erst_n)
    (!$past(run_e) && !run_e) |-> (cnt == $past(cnt)));

  assert_cmp_floor_R2: assert property (@(posedge eclk) disable iff (!erst_n)
    (mt_e != $past(mt_e)) |-> (cnt >= CMP_FLOOR));

  assert_flag_pair_R7: assert property (@(posedge bclk) disable iff (!brst_n)
    $rose(irq_f) |-> wake_f);

  assert_gray_step_R11: assert property (@(posedge bclk) disable iff (!brst_n)
    ($past(act_b) && act_b) |-> ($countones(g_s2 ^ $past(g_s2)) <= 1));

endmodule

// File: tb/tb_lp_cmp_timer.sv
module tb_lp_cmp_timer;
  localparam int CW = 10;
  localparam int MAXC = (1 << CW) - 1;

  logic bclk = 1'b0, eclk = 1'b0, brst_n = 1'b0, erst_n = 1'b0;
  logic bwe = 1'b0;
  logic [1:0] baddr = '0;
  logic [31:0] bwdata = '0, brdata;
  logic irq_o, wake_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  lp_cmp_timer #(.CNT_W(CW)) dut (
    .bclk(bclk), .brst_n(brst_n), .eclk(eclk), .erst_n(erst_n),
    .bwe(bwe), .baddr(baddr), .bwdata(bwdata), .brdata(brdata),
    .irq_o(irq_o), .wake_o(wake_o));

  always #4 bclk = ~bclk;
  initial begin #3; forever #16 eclk = ~eclk; end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitb(input int n);
    repeat (n) @(negedge bclk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge bclk); bwe = 1'b1; baddr = a; bwdata = v;
    @(negedge bclk); bwe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge bclk); baddr = a; #1; d = brdata;
  endtask

  function automatic logic [31:0] ctl(input bit run, input bit ien, input bit wen, input int psc);
    return 32'(run) | (32'(ien) << 1) | (32'(wen) << 2) | (32'(psc) << 8);
  endfunction

  task automatic wait_act(input bit v);
    logic [31:0] d;
    d = '0;
    for (int i = 0; i < 400; i++) begin
      rd(2'd0, d);
      if (d[31] == v) break;
    end
    chk(d[31] == v, "R9", "active bit settles", int'(d[31]), int'(v));
  endtask

  task automatic wait_flag(input int lim, output bit seen);
    logic [31:0] d;
    seen = 1'b0;
    for (int i = 0; i < lim; i++) begin
      rd(2'd2, d);
      if (d[0]) begin seen = 1'b1; break; end
    end
  endtask

  initial begin
    repeat (190000) @(posedge bclk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c0, c1, c2;
    bit seen;
    int pl[9] = '{0, 1, 2, 3, 4, 5, 6, 7, 127};
    int cl[5] = '{0, 1, 2, 3, 6};
    int eff, bad;

    waitb(4);
    erst_n = 1'b1; brst_n = 1'b1;
    waitb(4);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 0, "R1", "register reset value", int'(d), 0);
    end
    chk(irq_o == 1'b0 && wake_o == 1'b0, "R1", "outputs after reset", int'({irq_o, wake_o}), 0);

    // R6 immediate read-back, R9 active lags
    wr(2'd0, ctl(1, 0, 0, 0));
    rd(2'd0, d);
    chk(d[0] == 1'b1, "R6", "run bit read-back", int'(d[0]), 1);
    chk(d[31] == 1'b0, "R9", "active before sync", int'(d[31]), 0);
    wait_act(1'b1);
    wr(2'd1, 32'd123);
    rd(2'd1, d);
    chk(d == 123, "R6", "compare read-back", int'(d), 123);
    wr(2'd0, ctl(0, 0, 0, 0));
    wait_act(1'b0);

    // R3 prescale sweep with R5 restart
    foreach (pl[k]) begin
      wr(2'd0, ctl(1, 0, 0, pl[k]));
      wait_act(1'b1);
      rd(2'd3, c0);
      chk(c0 <= 3, "R5", "count after restart", int'(c0), 0);
      rd(2'd3, c1);
      waitb(256 * (pl[k] + 1));
      rd(2'd3, c2);
      eff = int'((c2 - c1) & MAXC);
      chk(eff >= 63 && eff <= 65, "R3", $sformatf("ticks with prescale %0d", pl[k]), eff, 64);
      wr(2'd0, ctl(0, 0, 0, pl[k]));
      wait_act(1'b0);
    end
    rd(2'd3, c1);
    waitb(64);
    rd(2'd3, c2);
    chk(c1 == c2, "R5", "count holds while stopped", int'(c2), int'(c1));

    // R2 compare floor, R7 flags, R10 outputs
    foreach (cl[k]) begin
      eff = (cl[k] < 2) ? 2 : cl[k];
      wr(2'd1, 32'(cl[k]));
      wr(2'd2, 32'd3);
      wr(2'd0, ctl(1, 1, 1, 3));
      wait_act(1'b1);
      rd(2'd2, d);
      chk(d == 0, "R7", "no flag before match", int'(d), 0);
      wait_flag(2000, seen);
      chk(seen, "R2", $sformatf("match seen for compare %0d", cl[k]), int'(seen), 1);
      rd(2'd3, c1);
      chk(int'(c1) >= eff && int'(c1) <= eff + 1, "R2", "count at match", int'(c1), eff);
      rd(2'd2, d);
      chk(d == 3, "R7", "both flags set", int'(d), 3);
      waitb(2);
      chk(irq_o && wake_o, "R10", "both outputs high", int'({irq_o, wake_o}), 3);
      wr(2'd0, ctl(0, 1, 1, 3));
      wait_act(1'b0);
      wr(2'd2, 32'd3);
      rd(2'd2, d);
      chk(d == 0, "R7", "single write clears both", int'(d), 0);
    end

    // R4 compare change while running, R11 coherent reads
    wr(2'd1, 32'd1000);
    wr(2'd2, 32'd3);
    wr(2'd0, ctl(1, 0, 0, 0));
    wait_act(1'b1);
    waitb(100);
    rd(2'd3, c1);
    wr(2'd1, 32'd300);
    rd(2'd1, d);
    chk(d == 300, "R6", "compare read-back while running", int'(d), 300);
    waitb(8);
    rd(2'd3, c2);
    chk(c2 >= c1 && c2 <= c1 + 6, "R4", "count undisturbed by compare write", int'(c2), int'(c1));
    rd(2'd2, d);
    chk(d == 0, "R4", "no match before new compare", int'(d), 0);
    bad = 0;
    rd(2'd3, c0);
    for (int i = 0; i < 200; i++) begin
      rd(2'd3, c1);
      if (((c1 - c0) & MAXC) > 1) bad++;
      c0 = c1;
    end
    chk(bad == 0, "R11", "consecutive count reads step by 0 or 1", bad, 0);
    wait_flag(3000, seen);
    rd(2'd3, c1);
    chk(seen && c1 >= 300 && c1 <= 302, "R4", "match at new compare", int'(c1), 300);
    wr(2'd0, ctl(0, 0, 0, 0));
    wait_act(1'b0);

    // R8 wrap and maximum compare, R10 gating, R7 separate clears
    wr(2'd1, 32'(MAXC));
    wr(2'd2, 32'd3);
    wr(2'd0, ctl(1, 0, 1, 0));
    wait_act(1'b1);
    wait_flag(6000, seen);
    rd(2'd3, c1);
    chk(seen && ((c1 + 1) & MAXC) <= 2, "R8", "match at maximum compare", int'(c1), MAXC);
    waitb(3);
    chk(irq_o == 1'b0, "R10", "interrupt gated by enable", int'(irq_o), 0);
    chk(wake_o == 1'b1, "R10", "wakeup output enabled", int'(wake_o), 1);
    waitb(40);
    rd(2'd3, c1);
    chk(c1 > 0 && c1 < 20, "R8", "count wrapped and running", int'(c1), 10);
    wr(2'd0, ctl(1, 1, 1, 0));
    waitb(3);
    chk(irq_o == 1'b1, "R10", "interrupt after enable", int'(irq_o), 1);
    wr(2'd2, 32'd1);
    rd(2'd2, d);
    chk(d == 2, "R7", "clear interrupt flag only", int'(d), 2);
    waitb(2);
    chk(irq_o == 1'b0 && wake_o == 1'b1, "R10", "outputs follow flags", int'({irq_o, wake_o}), 1);
    wr(2'd2, 32'd2);
    rd(2'd2, d);
    chk(d == 0, "R7", "clear wakeup flag", int'(d), 0);
    waitb(2);
    chk(wake_o == 1'b0, "R10", "wakeup output low", int'(wake_o), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule